// File: doc/BRIEF.md
# Four-Channel Priority Arbiter with Bus-Request Wait Pacing

This block chooses which of four transfer channels may move its next data unit and decides when the chosen channel's traffic should be escalated to a high-priority request for the shared bus. Each channel presents a request line and a two-bit priority level set by software. A global enable gates all granting. The grant is one-hot, lasts for a single data unit and is released when the channel signals that the unit is done. The block then re-arbitrates.

Escalation is paced by a six-bit wait limit. A counter measures clock edges since the most recent new channel request, meaning any request line going from low to high. While a grant is held, the high-priority bus request is raised once the counter has reached the limit. With a limit of zero the request is raised as soon as a grant is in place. A bus grant from the processor side clears the counter, and the count then starts again. A busy output reports that some channel is currently holding a grant.

Top module: `arb_tmo_top`

## Requirements
- R1: After reset, or while reset is low, `ch_gnt`, `hp_bus_req` and `any_busy` are all 0.
- R2: Channel i's priority is `ch_lvl[2*i+1:2*i]`, where 3 is the highest level and 0 the lowest. Among requesting channels, the one with the highest level is granted.
- R3: When several requesting channels share the highest level, the lowest-numbered channel is granted.
- R4: A grant appears on `ch_gnt` (bit i for channel i, at most one bit set) one clock edge after the block, idle and enabled, samples a request. The grant holds until the edge that samples `unit_done` high and is 0 after that edge. A new grant can follow one edge later.
- R5: While `glob_en` is 0 no grant is issued. A grant already held is withdrawn at the first edge that samples `glob_en` low.
- R6: `any_busy` is 1 exactly when a bit of `ch_gnt` is set.
- R7: With `wait_lim` = 0, `hp_bus_req` is 1 in every cycle in which a grant is held.
- R8: With `wait_lim` = L > 0, `hp_bus_req` is 0 until L clock edges have passed since the edge that sampled the latest new request, and 1 from then on while a grant is held. The count stops at 63.
- R9: Any request bit rising (sampled high after being sampled low) restarts the wait count, including while a grant is held.
- R10: An edge that samples `bus_gnt` high clears the wait count, so with L > 0 `hp_bus_req` is 0 in the next cycle and rises again L edges later.
- R11: `unit_done` sampled while no grant is held has no effect: no grant appears and `any_busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| glob_en | input | 1 | Global enable for granting |
| ch_req | input | 4 | Request line per channel |
| ch_lvl | input | 8 | Two-bit priority per channel, channel i at [2i+1:2i] |
| wait_lim | input | 6 | Wait limit in clock edges before escalation |
| unit_done | input | 1 | The granted channel finished its data unit |
| bus_gnt | input | 1 | Processor side granted the bus |
| ch_gnt | output | 4 | One-hot channel grant |
| hp_bus_req | output | 1 | High-priority bus request |
| any_busy | output | 1 | A channel holds a grant |

## Verification
Arbitration and wait pacing act in the same cycles. A second, higher-priority channel raises its request while a lower one holds its grant. The bench then judges two things at once: the grant must not move, and the wait count must restart, so the escalation shifts later by exactly the number of edges already elapsed. A second case drives a bus grant while a grant is held. The check is that the escalation drops for the full wait limit and returns without the channel grant changing.

// File: rtl/arb_tmo_pkg.sv
// Package: shared sizes and types of the channel arbiter with wait pacing.
// Assumes: four channels, two-bit levels, six-bit wait limit.
package arb_tmo_pkg;
    localparam int unsigned CH_N  = 4;
    localparam int unsigned LVL_W = 2;
    localparam int unsigned TMO_W = 6;

    // Grant sequencer states.
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_HOLD = 2'd1,
        GS_GAP  = 2'd2
    } gnt_state_e;
endpackage

// File: rtl/arb_tmo_select.sv
// Module: arb_tmo_select
// Picks the requesting channel with the highest level; ties go to the
// lowest index. Purely combinational. Assumes the level field of channel i
// sits at [i*LVL_W +: LVL_W] in the packed level vector.
module arb_tmo_select #(
    parameter int unsigned CH_N  = 4,
    parameter int unsigned LVL_W = 2
) (
    input  logic [CH_N-1:0]       req,
    input  logic [CH_N*LVL_W-1:0] lvl,
    output logic [CH_N-1:0]       win_oh,
    output logic                  win_any
);
    localparam int unsigned IDX_W = (CH_N > 1) ? $clog2(CH_N) : 1;

    logic [LVL_W-1:0] lvl_ch [CH_N];

    // Split the packed level vector into per-channel fields.
    for (genvar g = 0; g < CH_N; g++) begin : g_split
        assign lvl_ch[g] = lvl[g*LVL_W +: LVL_W];
    end

    logic [IDX_W-1:0] best_idx;
    logic [LVL_W-1:0] best_lvl;
    logic             found;

    // Scan upward; a strict compare keeps the lowest index on ties.
    always_comb begin
        best_idx = '0;
        best_lvl = '0;
        found    = 1'b0;
        for (int i = 0; i < CH_N; i++) begin
            if (req[i] && (!found || (lvl_ch[i] > best_lvl))) begin
                best_idx = IDX_W'(i);
                best_lvl = lvl_ch[i];
                found    = 1'b1;
            end
        end
    end

    // Expand the winning index to a one-hot vector.
    always_comb begin
        win_oh = '0;
        if (found) begin
            win_oh[best_idx] = 1'b1;
        end
    end

    assign win_any = found;
endmodule

// File: rtl/arb_tmo_sequencer.sv
// Module: arb_tmo_sequencer
// Holds a one-hot grant for one data unit, releases it on unit_done, leaves
// one gap cycle, then accepts the next winner. The global enable withdraws
// any grant and blocks new ones. Assumes win_oh is one-hot or zero.
module arb_tmo_sequencer
    import arb_tmo_pkg::*;
#(
    parameter int unsigned CH_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glob_en,
    input  logic [CH_N-1:0] win_oh,
    input  logic            win_any,
    input  logic            unit_done,
    output logic [CH_N-1:0] gnt_q
);
    gnt_state_e state_q;

    // State and grant register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            gnt_q   <= '0;
        end else if (!glob_en) begin
            state_q <= GS_IDLE;
            gnt_q   <= '0;
        end else begin
            case (state_q)
                GS_IDLE: begin
                    if (win_any) begin
                        state_q <= GS_HOLD;
                        gnt_q   <= win_oh;
                    end
                end
                GS_HOLD: begin
                    if (unit_done) begin
                        state_q <= GS_GAP;
                        gnt_q   <= '0;
                    end
                end
                GS_GAP: begin
                    if (win_any) begin
                        state_q <= GS_HOLD;
                        gnt_q   <= win_oh;
                    end else begin
                        state_q <= GS_IDLE;
                    end
                end
                default: begin
                    state_q <= GS_IDLE;
                    gnt_q   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/arb_tmo_pacer.sv
// Module: arb_tmo_pacer
// Counts clock edges since the latest rising request (saturating) and
// raises the high-priority bus request while a grant is held and the
// count has reached the wait limit. A bus grant clears the count.
// Assumes request lines are synchronous to clk.
module arb_tmo_pacer #(
    parameter int unsigned CH_N  = 4,
    parameter int unsigned TMO_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_N-1:0]  req,
    input  logic             gnt_any,
    input  logic             bus_gnt,
    input  logic [TMO_W-1:0] wait_lim,
    output logic             hp_req
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [CH_N-1:0]  req_q;
    logic [TMO_W-1:0] cnt_q;
    logic             new_req;

    // Remember the previous request vector for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req;
        end
    end

    assign new_req = |(req & ~req_q);

    // Wait counter: cleared by bus grant or new request, else saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bus_gnt || new_req) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Escalate only while a channel holds a grant and the wait has elapsed.
    assign hp_req = gnt_any && (cnt_q >= wait_lim);
endmodule

// File: rtl/arb_tmo_top.sv
// Module: arb_tmo_top
// Four-channel priority arbiter with paced high-priority bus request.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module arb_tmo_top
    import arb_tmo_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   glob_en,
    input  logic [CH_N-1:0]        ch_req,
    input  logic [CH_N*LVL_W-1:0]  ch_lvl,
    input  logic [TMO_W-1:0]       wait_lim,
    input  logic                   unit_done,
    input  logic                   bus_gnt,
    output logic [CH_N-1:0]        ch_gnt,
    output logic                   hp_bus_req,
    output logic                   any_busy
);
    logic [CH_N-1:0] win_oh;
    logic            win_any;
    logic [CH_N-1:0] gnt_q;

    arb_tmo_select #(.CH_N(CH_N), .LVL_W(LVL_W)) u_select (
        .req     (ch_req),
        .lvl     (ch_lvl),
        .win_oh  (win_oh),
        .win_any (win_any)
    );

    arb_tmo_sequencer #(.CH_N(CH_N)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .glob_en   (glob_en),
        .win_oh    (win_oh),
        .win_any   (win_any),
        .unit_done (unit_done),
        .gnt_q     (gnt_q)
    );

    arb_tmo_pacer #(.CH_N(CH_N), .TMO_W(TMO_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (ch_req),
        .gnt_any  (|gnt_q),
        .bus_gnt  (bus_gnt),
        .wait_lim (wait_lim),
        .hp_req   (hp_bus_req)
    );

    assign ch_gnt   = gnt_q;
    assign any_busy = |gnt_q;
endmodule

// File: rtl/arb_tmo_chk.sv
// Module: arb_tmo_chk
// Property checker for arb_tmo_top, attached by bind below.
module arb_tmo_chk
    import arb_tmo_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  glob_en,
    input logic [CH_N-1:0]       ch_req,
    input logic [TMO_W-1:0]      wait_lim,
    input logic                  unit_done,
    input logic [CH_N-1:0]       ch_gnt,
    input logic                  hp_bus_req,
    input logic                  any_busy
);
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_gnt));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_gnt && !unit_done && glob_en) |=> $stable(ch_gnt));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_gnt && unit_done) |=> (ch_gnt == '0));

    p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (ch_gnt == '0));

    p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_busy == (|ch_gnt));

    p_zero_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_lim == '0 && |ch_gnt) |-> hp_bus_req);

    p_hp_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hp_bus_req |-> (|ch_gnt));

    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_gnt == '0 && ch_req == '0) |=> (ch_gnt == '0));
endmodule

bind arb_tmo_top arb_tmo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .ch_req     (ch_req),
    .wait_lim   (wait_lim),
    .unit_done  (unit_done),
    .ch_gnt     (ch_gnt),
    .hp_bus_req (hp_bus_req),
    .any_busy   (any_busy)
);

// File: tb/tb_arb_tmo_top.sv
module tb_arb_tmo_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       glob_en;
    logic [3:0] ch_req;
    logic [7:0] ch_lvl;
    logic [5:0] wait_lim;
    logic       unit_done;
    logic       bus_gnt;
    logic [3:0] ch_gnt;
    logic       hp_bus_req;
    logic       any_busy;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    arb_tmo_top dut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ch_req(ch_req),
        .ch_lvl(ch_lvl), .wait_lim(wait_lim), .unit_done(unit_done),
        .bus_gnt(bus_gnt), .ch_gnt(ch_gnt), .hp_bus_req(hp_bus_req),
        .any_busy(any_busy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [5:0] lim);
        rst_n = 1'b0; glob_en = 1'b1; ch_req = '0; ch_lvl = '0;
        wait_lim = lim; unit_done = 1'b0; bus_gnt = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset(6'd0);
        chk("R1 gnt", ch_gnt, 0);
        chk("R1 hp", hp_bus_req, 0);
        chk("R1 busy", any_busy, 0);
    endtask

    task automatic t_priority();
        do_reset(6'd0);
        ch_lvl = {2'd1, 2'd3, 2'd1, 2'd1};
        ch_req = 4'b1111;
        tick();
        chk("R2 highest level wins", ch_gnt, 4'b0100);
        chk("R6 busy with grant", any_busy, 1);
        tick();
        chk("R4 grant held", ch_gnt, 4'b0100);
        unit_done = 1'b1; ch_lvl = {2'd2, 2'd0, 2'd2, 2'd2};
        tick();
        unit_done = 1'b0;
        chk("R4 released after unit", ch_gnt, 0);
        chk("R6 busy clear", any_busy, 0);
        tick();
        chk("R3 tie lowest index", ch_gnt, 4'b0001);
        unit_done = 1'b1; ch_lvl = {2'd2, 2'd0, 2'd2, 2'd1};
        tick();
        unit_done = 1'b0;
        tick();
        chk("R3 tie among 1 and 3", ch_gnt, 4'b0010);
    endtask

    task automatic t_enable();
        do_reset(6'd0);
        glob_en = 1'b0; ch_req = 4'b0011;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5 no grant when disabled", ch_gnt, 0);
        end
        glob_en = 1'b1;
        tick();
        chk("R5 grant after enable", ch_gnt, 4'b0001);
        glob_en = 1'b0;
        tick();
        chk("R5 grant withdrawn", ch_gnt, 0);
        chk("R7 no hp without grant", hp_bus_req, 0);
    endtask

    task automatic t_idle_done();
        do_reset(6'd0);
        unit_done = 1'b1;
        tick(); tick();
        unit_done = 1'b0;
        chk("R11 gnt stays 0", ch_gnt, 0);
        chk("R11 busy stays 0", any_busy, 0);
        ch_req = 4'b1000;
        tick();
        chk("R11 later grant normal", ch_gnt, 4'b1000);
    endtask

    task automatic t_zero_wait();
        do_reset(6'd0);
        ch_req = 4'b0010;
        tick();
        chk("R7 hp immediately", hp_bus_req, 1);
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
        chk("R7 hp kept at zero wait", hp_bus_req, 1);
    endtask

    task automatic t_wait_restart();
        do_reset(6'd5);
        ch_req = 4'b0001;
        tick();
        chk("R8 grant given", ch_gnt, 4'b0001);
        chk("R8 hp low at start", hp_bus_req, 0);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R8 hp still waiting", hp_bus_req, 0);
        end
        tick();
        chk("R8 hp after 5 edges", hp_bus_req, 1);
        // restart: new request on higher level channel
        do_reset(6'd5);
        ch_req = 4'b0001; ch_lvl = {2'd0, 2'd0, 2'd3, 2'd0};
        tick(); tick(); tick();
        ch_req = 4'b0011;
        tick();
        chk("R9 grant not moved", ch_gnt, 4'b0001);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R9 count restarted", hp_bus_req, 0);
        end
        tick();
        chk("R9 hp after restart", hp_bus_req, 1);
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
        chk("R10 hp cleared by bus grant", hp_bus_req, 0);
        chk("R10 grant kept", ch_gnt, 4'b0001);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R10 waiting again", hp_bus_req, 0);
        end
        tick();
        chk("R10 hp returns", hp_bus_req, 1);
    endtask

    initial begin
        t_reset();
        t_priority();
        t_enable();
        t_idle_done();
        t_zero_wait();
        t_wait_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule